// File: doc/BRIEF.md
# I2C EEPROM Target

This block is an I2C target that looks to a bus master like a small serial EEPROM. A fast system clock oversamples the SCL and SDA lines through two-flop synchronizers. The block detects START, repeated START and STOP conditions, and it answers when the 7-bit device address matches. It then takes a word address of one or two bytes, and either stores one data byte or returns stored bytes to the master. The SDA line is open drain. The block only ever asks for the line to be pulled low through `sda_pull`. The board's pull-up provides the high level.

A write transaction is START, device address with the write bit, the word address, one data byte, then STOP. A random read is a dummy write of the word address, then a repeated START, then the device address with the read bit. The target then shifts out the byte at the latched address. Each master ACK moves on to the next location, and a master NACK ends the read. The pin `addr16_sel` is static. It selects one or two word-address bytes, and only the low 8 bits index the 256-byte array.

The controller states are:
- `ST_IDLE`: waiting for a START.
- `ST_DEVICE` and `ST_DEVICE_ACK`: device byte and its acknowledge.
- `ST_OFS_HI` and `ST_OFS_HI_ACK`: high word-address byte and its acknowledge.
- `ST_OFS_LO` and `ST_OFS_LO_ACK`: low word-address byte and its acknowledge.
- `ST_WRITE` and `ST_WRITE_ACK`: data byte and its acknowledge.
- `ST_READ`: the target shifts out a byte.
- `ST_READ_ACK`: the master acknowledges that byte.
- `ST_IGNORE`: the target has dropped out of the transaction.

The transitions are:
- START from any state goes to `ST_DEVICE`.
- STOP from any state goes to `ST_IDLE`.
- The eighth-bit SCL fall of a byte state moves to its ACK state. From `ST_DEVICE` it moves to `ST_IGNORE` instead when the address does not match.
- The next SCL fall leaves an ACK state:
  - `ST_DEVICE_ACK` goes to `ST_READ` for the read bit, to `ST_OFS_HI` in two-byte mode, or to `ST_OFS_LO` otherwise.
  - `ST_OFS_HI_ACK` goes to `ST_OFS_LO`.
  - `ST_OFS_LO_ACK` goes to `ST_WRITE`.
  - `ST_WRITE_ACK` goes to `ST_IGNORE`.
  - `ST_READ_ACK` goes back to `ST_READ` on a master ACK, or to `ST_IDLE` on a NACK.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_pull` is 0 and every one of the 256 memory locations reads back as 0x00.
- R2: A START (SDA falls while SCL is high) begins reception of a new device byte from any state, including in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle with `sda_pull` at 0.
- R3: The first byte after a START is the 7-bit device address, MSB first, followed by the R/W bit (1 = read, 0 = write). When the address equals the parameter `DEV_ADDR` (default 7'b1010000), the target acknowledges.
- R4: When the device address does not match, the target gives no acknowledge. `sda_pull` stays 0 until the next START or STOP, and no byte sent in that transaction changes the memory.
- R5: For an acknowledged byte, `sda_pull` is 1 for the whole 9th SCL high phase and is released after that clock's falling edge. `sda_pull` never changes while SCL stays high, except in response to a START or STOP.
- R6: With `addr16_sel`=0, one word-address byte follows a write-addressed device byte.
- R7: With `addr16_sel`=1, two word-address bytes follow, high byte first. Only the low 8 bits of the word address select the memory location.
- R8: The data byte after the word address is stored at that address and acknowledged. A further data byte in the same transaction is neither acknowledged nor stored.
- R9: After a read-addressed device byte, the target drives the byte at the latched word address, MSB first, starting right after the acknowledge. The latched address survives a STOP, so a read with no preceding dummy write returns that same location.
- R10: After each read byte the target releases SDA. A master ACK (SDA low) makes it send the byte at the next address, wrapping from 0xFF to 0x00. A master NACK (SDA high) ends the read, and `sda_pull` stays 0 until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr16_sel | input | 1 | Static select: 1 = two-byte word address, 0 = one-byte word address |
| sda_pull | output | 1 | Open-drain enable; 1 pulls SDA low, 0 releases it |

## Verification
The bench drives a repeated START in the middle of a data byte. A design that only honoured START in idle would keep counting bits and store garbage. It sends a wrong device address followed by bytes that would overwrite a known location. A target that acknowledged anyway, or latched those bytes, would be caught by the read-back and by the released-line checks. Sequential reads cross 0xFF. Reads in two-byte mode land on the low byte, which catches a wrong wrap or the wrong choice of address byte. The bench also clocks on past a master NACK, which exposes a target that keeps driving data.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVICE,
        ST_DEVICE_ACK,
        ST_OFS_HI,
        ST_OFS_HI_ACK,
        ST_OFS_LO,
        ST_OFS_LO_ACK,
        ST_WRITE,
        ST_WRITE_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Bus lines idle high, so the chains reset to ones.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_mem.sv
module i2c_tgt_mem #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we) |-> (mem_q[$past(waddr)] == $past(wdata))); // R8

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1010000,
    parameter int         MEM_AW   = 8,
    parameter int         WADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              addr16_sel,
    input  logic [7:0]        rd_data,
    output logic              sda_pull,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);
    localparam logic [3:0] ACK_BIT  = 4'(BYTE_W + 1);

    tgt_state_e         state_q, state_d;
    logic [3:0]         bit_cnt_q;
    logic [7:0]         rx_q;
    logic [7:0]         tx_q;
    logic [7:0]         ofs_hi_q;
    logic [WADDR_W-1:0] word_addr_q;
    logic               rw_q;
    logic               byte_done;

    assign byte_done = scl_fall && (bit_cnt_q == LAST_BIT);

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEVICE;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_DEVICE:     if (byte_done)
                                   state_d = (rx_q[7:1] == DEV_ADDR) ? ST_DEVICE_ACK : ST_IGNORE;
                ST_DEVICE_ACK: if (scl_fall) begin
                                   if (rw_q)            state_d = ST_READ;
                                   else if (addr16_sel) state_d = ST_OFS_HI;
                                   else                 state_d = ST_OFS_LO;
                               end
                ST_OFS_HI:     if (byte_done) state_d = ST_OFS_HI_ACK;
                ST_OFS_HI_ACK: if (scl_fall)  state_d = ST_OFS_LO;
                ST_OFS_LO:     if (byte_done) state_d = ST_OFS_LO_ACK;
                ST_OFS_LO_ACK: if (scl_fall)  state_d = ST_WRITE;
                ST_WRITE:      if (byte_done) state_d = ST_WRITE_ACK;
                ST_WRITE_ACK:  if (scl_fall)  state_d = ST_IGNORE;
                ST_READ:       if (byte_done) state_d = ST_READ_ACK;
                ST_READ_ACK:   if (scl_fall)  state_d = rx_q[0] ? ST_IDLE : ST_READ;
                ST_IGNORE:     state_d = ST_IGNORE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q   <= '0;
            rx_q        <= '0;
            tx_q        <= '0;
            ofs_hi_q    <= '0;
            word_addr_q <= '0;
            rw_q        <= 1'b0;
        end else begin
            if (start_det || (state_d != state_q)) begin
                bit_cnt_q <= '0;
            end else if (scl_rise && (bit_cnt_q != ACK_BIT)) begin
                bit_cnt_q <= bit_cnt_q + 4'd1;
            end

            if (scl_rise) begin
                rx_q <= {rx_q[6:0], sda_s};
            end

            if (state_q == ST_DEVICE && byte_done) begin
                rw_q <= rx_q[0];
            end

            if (state_q == ST_OFS_HI && byte_done) begin
                ofs_hi_q <= rx_q;
            end

            if (state_q == ST_OFS_LO && byte_done) begin
                word_addr_q <= addr16_sel ? WADDR_W'({ofs_hi_q, rx_q})
                                          : WADDR_W'(rx_q);
            end else if (state_q == ST_READ && byte_done) begin
                word_addr_q <= word_addr_q + 1'b1;
            end

            if (state_d == ST_READ && state_q != ST_READ) begin
                tx_q <= rd_data;
            end else if (state_q == ST_READ && scl_fall) begin
                tx_q <= {tx_q[6:0], 1'b1};
            end
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_DEVICE_ACK,
            ST_OFS_HI_ACK,
            ST_OFS_LO_ACK,
            ST_WRITE_ACK:  sda_pull = 1'b1;
            ST_READ:       sda_pull = ~tx_q[7];
            default:       sda_pull = 1'b0;
        endcase
    end

    assign mem_we    = (state_q == ST_WRITE) && byte_done;
    assign mem_addr  = word_addr_q[MEM_AW-1:0];
    assign mem_wdata = rx_q;

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull); // R2

    AST_PULL_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_pull)); // R5

    AST_NO_ACK_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_DEVICE && byte_done && rx_q[7:1] != DEV_ADDR) |-> !sda_pull); // R4

    AST_READ_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q) == ST_DEVICE_ACK) |-> (sda_pull == !$past(rd_data[7]))); // R9

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
    parameter logic [6:0] DEV_ADDR    = 7'b1010000,
    parameter int         MEM_DEPTH   = 256,
    parameter int         WADDR_W     = 16,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr16_sel,
    output logic sda_pull
);

    localparam int MEM_AW = $clog2(MEM_DEPTH);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .MEM_AW   (MEM_AW),
        .WADDR_W  (WADDR_W)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr16_sel (addr16_sel),
        .rd_data    (mem_rdata),
        .sda_pull   (sda_pull),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    i2c_tgt_mem #(.AW(MEM_AW)) mem_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb_top;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst_scl = 1'b1;
    logic mst_sda = 1'b1;
    logic addr16_sel = 1'b0;
    logic sda_pull;
    logic sda_line;

    int    checks = 0;
    int    fails = 0;
    int    exp_pull = -1;
    string exp_tag = "";
    bit    done = 0;
    int    ref_mem [256];

    always #2 clk = ~clk;

    assign sda_line = mst_sda & ~sda_pull;

    i2c_eeprom_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (mst_scl),
        .sda_i      (sda_line),
        .addr16_sel (addr16_sel),
        .sda_pull   (sda_pull)
    );

    // Per-clock comparison of the pull output against the model's expectation
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_pull >= 0) begin
            checks++;
            if (sda_pull !== exp_pull[0]) begin
                fails++;
                $display("FAIL %s: sda_pull actual %b expected %0d at %0t", exp_tag, sda_pull, exp_pull, $time);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, input int ex, input string tag, output logic seen);
        mst_sda = b;
        wait_cyc(Q);
        mst_scl = 1'b1;
        wait_cyc(4);
        exp_tag  = tag;
        exp_pull = ex;
        wait_cyc(6);
        seen = sda_line;
        wait_cyc(6);
        exp_pull = -1;
        mst_scl  = 1'b0;
        wait_cyc(Q);
    endtask

    task automatic start_cond();
        if (!mst_scl) begin
            mst_sda = 1'b1;
            wait_cyc(Q);
            mst_scl = 1'b1;
            wait_cyc(2*Q);
        end
        mst_sda = 1'b0;
        wait_cyc(2*Q);
        mst_scl = 1'b0;
        wait_cyc(Q);
    endtask

    task automatic stop_cond();
        mst_sda = 1'b0;
        wait_cyc(Q);
        mst_scl = 1'b1;
        wait_cyc(2*Q);
        mst_sda = 1'b1;
        wait_cyc(4);
        exp_tag  = "R2";
        exp_pull = 0;
        wait_cyc(2*Q);
        exp_pull = -1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack_exp, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 0, tag, s);
        bit_cycle(1'b1, ack_exp ? 1 : 0, ack_exp ? "R5" : tag, s);
    endtask

    task automatic recv_byte(input int expb, input bit mack, input string tag);
        logic       s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, expb[i] ? 0 : 1, tag, s);
            got[i] = s;
        end
        chk(got == expb[7:0], tag, got, expb);
        bit_cycle(mack ? 1'b0 : 1'b1, 0, "R10", s);
    endtask

    task automatic wr_byte(input int a, input int d, input bit a16);
        addr16_sel = a16;
        start_cond();
        send_byte(8'hA0, 1, "R3");
        if (a16) send_byte(a[15:8], 1, "R7");
        send_byte(a[7:0], 1, "R6");
        send_byte(d[7:0], 1, "R8");
        stop_cond();
        ref_mem[a % 256] = d;
    endtask

    task automatic rd_rand(input int a, input bit a16, input int n, input string tag);
        addr16_sel = a16;
        start_cond();
        send_byte(8'hA0, 1, "R3");
        if (a16) send_byte(a[15:8], 1, "R7");
        send_byte(a[7:0], 1, "R6");
        start_cond();
        send_byte(8'hA1, 1, "R9");
        for (int k = 0; k < n; k++) recv_byte(ref_mem[(a + k) % 256], k < n - 1, tag);
        stop_cond();
    endtask

    initial begin
        logic s;
        for (int i = 0; i < 256; i++) ref_mem[i] = 0;
        wait_cyc(10);
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);
        rst_n = 1'b1;
        wait_cyc(10);
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);

        // R6 / R8: one-byte word address writes
        wr_byte(8'h12, 8'h3C, 0);
        wr_byte(8'h13, 8'hA5, 0);

        // R9: random read; R10: sequential read
        rd_rand(8'h12, 0, 1, "R9");
        rd_rand(8'h12, 0, 2, "R10");

        // R1: untouched location reads zero
        rd_rand(8'h50, 0, 1, "R1");

        // R4: wrong device address, bytes must not land
        start_cond();
        send_byte(8'hA2, 0, "R4");
        send_byte(8'h12, 0, "R4");
        send_byte(8'hFF, 0, "R4");
        stop_cond();
        rd_rand(8'h12, 0, 1, "R4");

        // R8: second data byte refused
        start_cond();
        send_byte(8'hA0, 1, "R3");
        send_byte(8'h20, 1, "R6");
        send_byte(8'h11, 1, "R8");
        send_byte(8'h22, 0, "R8");
        stop_cond();
        ref_mem[8'h20] = 8'h11;
        rd_rand(8'h20, 0, 2, "R8");

        // R7: two-byte word address, low byte selects location
        wr_byte(16'h0140, 8'h5A, 1);
        rd_rand(16'h0140, 1, 1, "R7");
        rd_rand(8'h40, 0, 1, "R7");

        // R10: wrap from 0xFF to 0x00
        wr_byte(8'hFF, 8'h77, 0);
        wr_byte(8'h00, 8'h88, 0);
        rd_rand(8'hFF, 0, 2, "R10");

        // R9: latched address survives STOP
        addr16_sel = 1'b0;
        start_cond();
        send_byte(8'hA0, 1, "R3");
        send_byte(8'h13, 1, "R6");
        stop_cond();
        start_cond();
        send_byte(8'hA1, 1, "R9");
        recv_byte(ref_mem[8'h13], 0, "R9");
        stop_cond();

        // R10: after master NACK the target stays off the line
        start_cond();
        send_byte(8'hA0, 1, "R3");
        send_byte(8'h12, 1, "R6");
        start_cond();
        send_byte(8'hA1, 1, "R9");
        recv_byte(ref_mem[8'h12], 0, "R10");
        for (int i = 0; i < 9; i++) bit_cycle(1'b1, 0, "R10", s);
        stop_cond();

        // R2: repeated START in the middle of a byte restarts reception
        start_cond();
        send_byte(8'hA0, 1, "R3");
        for (int i = 0; i < 4; i++) bit_cycle(i[0], 0, "R2", s);
        start_cond();
        send_byte(8'hA0, 1, "R2");
        send_byte(8'h30, 1, "R2");
        send_byte(8'h99, 1, "R2");
        stop_cond();
        ref_mem[8'h30] = 8'h99;
        rd_rand(8'h30, 0, 1, "R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule